// File: doc/BRIEF.md
# Dual-Order Burst Address Counter

This block produces the address for a four-beat burst on a synchronous cache SRAM. When the bus accepts an address strobe, the block captures the external address and moves to the first beat. After that it walks the two lowest address bits through the other three beats each time the advance strobe is sampled active. The upper address bits do not change during the burst.

The order-select input is meant to be tied at board level. It picks one of two orders. Interleaved order flips bits of the start offset. Linear order counts upward and wraps inside the aligned four-word group. A suspend holds the current address for as many cycles as it lasts. A fresh strobe always restarts the burst, even when the advance strobe is active in the same cycle. All state changes on the rising clock edge, and a synchronous reset clears the state.

Top module: `burst_addr_counter`

## Requirements
- R1: A synchronous active-high reset sets `addr` to zero and `beat` to zero on the next rising edge.
- R2: When `load` is high on a rising edge, `addr` equals the `ext_addr` value sampled at that edge and `beat` is 0 after the edge.
- R3: With `order_sel` high (interleaved order), `addr[1:0]` equals the start offset XOR `beat`. Start offsets 0, 1, 2 and 3 give the sequences 0,1,2,3 / 1,0,3,2 / 2,3,0,1 / 3,2,1,0.
- R4: With `order_sel` low (linear order), `addr[1:0]` equals the start offset plus `beat`, modulo 4. Start offsets 0, 1, 2 and 3 give the sequences 0,1,2,3 / 1,2,3,0 / 2,3,0,1 / 3,0,1,2.
- R5: When `load` is low and `adv_n` is low on a rising edge, `beat` increments by one, and it wraps from 3 to 0.
- R6: When `load` is low and `adv_n` is high on a rising edge, `beat` and `addr` keep their values (suspend).
- R7: `addr[AW-1:2]` changes only on a load. After the fourth beat, a further advance returns `addr[1:0]` to the start offset without carrying into the upper bits.
- R8: A high `load` takes priority over a low `adv_n` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Address strobe accepted; captures `ext_addr` |
| ext_addr | input | AW | Start address from the bus |
| adv_n | input | 1 | Advance strobe, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | output | AW | Current burst address |
| beat | output | 2 | Burst position, 0 for the first beat |

## Verification
Directed bursts run every start offset in both orders and continue past the fourth beat. This separates XOR ordering from additive ordering, because the two differ only for odd start offsets. It also exposes any carry into the upper bits at the wrap. Suspend runs of several cycles placed between advances show whether a held beat is lost or counted twice. Loads issued while `adv_n` is low test priority. A long random run then mixes loads, advances and order changes against a bench model.

// File: rtl/burst_addr_counter.sv
module burst_addr_counter #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ext_addr,
  input  logic          adv_n,
  input  logic          order_sel,
  output logic [AW-1:0] addr,
  output logic [1:0]    beat
);

  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  logic [1:0]    low_ilv;
  logic [1:0]    low_lin;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= 2'd0;
    end else if (load) begin
      base_q <= ext_addr;
      beat_q <= 2'd0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low_ilv = base_q[1:0] ^ beat_q;
  assign low_lin = base_q[1:0] + beat_q;

  assign addr = {base_q[AW-1:2], order_sel ? low_ilv : low_lin};
  assign beat = beat_q;

endmodule

module burst_addr_counter_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic [AW-1:0] ext_addr,
  input logic          adv_n,
  input logic          order_sel,
  input logic [AW-1:0] addr,
  input logic [1:0]    beat
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr == '0 && beat == 2'd0));

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat == 2'd0 && addr[AW-1:2] == $past(ext_addr[AW-1:2])));

  // R8: load wins over an active advance
  p_load_priority_r8: assert property (@(posedge clk) disable iff (rst)
    (load && !adv_n) |=> beat == 2'd0);

  p_interleave_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && order_sel) |=>
      (!order_sel || ((addr[1:0] ^ beat) == $past(addr[1:0] ^ beat))));

  p_linear_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && !order_sel) |=>
      (order_sel || ((addr[1:0] - beat) == $past(addr[1:0] - beat))));

  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> beat == $past(beat) + 2'd1);

  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> ($stable(beat) && (!$stable(order_sel) || $stable(addr))));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> addr[AW-1:2] == $past(addr[AW-1:2]));

endmodule

bind burst_addr_counter burst_addr_counter_chk #(.AW(AW)) chk_i (.*);

// File: tb/burst_addr_counter_tb_top.sv
`timescale 1ns/1ps
module burst_addr_counter_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          load;
  logic [AW-1:0] ext_addr;
  logic          adv_n;
  logic          order_sel;
  logic [AW-1:0] addr;
  logic [1:0]    beat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;

  always #5 clk = ~clk;

  burst_addr_counter #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .load(load), .ext_addr(ext_addr),
    .adv_n(adv_n), .order_sel(order_sel), .addr(addr), .beat(beat)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b,
                                             input logic [1:0] k,
                                             input logic o);
    logic [1:0] lo;
    lo = o ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got,
                       input logic [AW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic ld, input logic [AW-1:0] ea,
                      input logic an, input logic os);
    rst = r; load = ld; ext_addr = ea; adv_n = an; order_sel = os;
    @(posedge clk);
    if (r) begin m_base = '0; m_beat = 2'd0; end
    else if (ld) begin m_base = ea; m_beat = 2'd0; end
    else if (!an) m_beat = m_beat + 2'd1;
    @(negedge clk);
  endtask

  task automatic burst(input string tag, input logic os, input logic [AW-1:0] start,
                       input logic [1:0] s0, input logic [1:0] s1,
                       input logic [1:0] s2, input logic [1:0] s3);
    logic [1:0] seq [5];
    seq[0] = s0; seq[1] = s1; seq[2] = s2; seq[3] = s3; seq[4] = s0;
    step(1'b0, 1'b1, start, 1'b1, os);
    for (int i = 0; i < 5; i++) begin
      check({tag, " low bits"}, {{(AW-2){1'b0}}, addr[1:0]}, {{(AW-2){1'b0}}, seq[i]});
      check("R7 upper bits", {addr[AW-1:2], 2'b00}, {start[AW-1:2], 2'b00});
      step(1'b0, 1'b0, '0, 1'b0, os);
    end
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; ext_addr = '0; adv_n = 1'b1; order_sel = 1'b1;
    m_base = '0; m_beat = 2'd0;
    @(negedge clk);
    step(1'b1, 1'b0, '0, 1'b1, 1'b1);
    check("R1 reset addr", addr, '0);
    check("R1 reset beat", {{(AW-2){1'b0}}, beat}, '0);

    step(1'b0, 1'b1, 16'hABCE, 1'b1, 1'b1);
    check("R2 load addr", addr, 16'hABCE);
    check("R2 load beat", {{(AW-2){1'b0}}, beat}, '0);

    burst("R3 ilv start2", 1'b1, 16'h1232, 2'd2, 2'd3, 2'd0, 2'd1);
    burst("R3 ilv start1", 1'b1, 16'h7FF1, 2'd1, 2'd0, 2'd3, 2'd2);
    burst("R3 ilv start3", 1'b1, 16'hFFFF, 2'd3, 2'd2, 2'd1, 2'd0);
    burst("R4 lin start3", 1'b0, 16'hFFFF, 2'd3, 2'd0, 2'd1, 2'd2);
    burst("R4 lin start1", 1'b0, 16'h4441, 2'd1, 2'd2, 2'd3, 2'd0);
    burst("R4 lin start2", 1'b0, 16'h0002, 2'd2, 2'd3, 2'd0, 2'd1);

    step(1'b0, 1'b1, 16'h5551, 1'b1, 1'b0);
    step(1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R5 advance beat", {{(AW-2){1'b0}}, beat}, 16'd1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0);
      check("R6 suspend addr", addr, 16'h5552);
      check("R6 suspend beat", {{(AW-2){1'b0}}, beat}, 16'd1);
    end

    step(1'b0, 1'b1, 16'h9993, 1'b0, 1'b1);
    check("R8 load priority beat", {{(AW-2){1'b0}}, beat}, '0);
    check("R8 load priority addr", addr, 16'h9993);

    for (int i = 0; i < 4000; i++) begin
      logic ld, an, os;
      logic [AW-1:0] ea;
      ld = ($urandom % 5) == 0;
      an = $urandom % 2;
      ea = AW'($urandom);
      os = ld ? 1'($urandom % 2) : order_sel;
      step(1'b0, ld, ea, an, os);
      check(ld ? "R2 random load" : (an ? "R6 random hold" : (os ? "R3 random ilv" : "R4 random lin")),
            addr, exp_addr(m_base, m_beat, os));
      check("R5 random beat", {{(AW-2){1'b0}}, beat}, {{(AW-2){1'b0}}, m_beat});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule